// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Bank

This block holds three independent down-counters that share one system clock. A prescaler turns that clock into a base tick at a nominal 2 MHz, and then into slower ticks at one half, one quarter and one eighth of that rate. Each counter picks one of these four rates for itself. It only counts while its run bit is set. When it steps past zero, it reloads from its programmed value. If its interrupt enable is set at that moment, it also raises a sticky event flag. All three flags are ORed into a single interrupt line.

Software talks to the block over a simple synchronous register bus: a write strobe, a read strobe, a 4-bit word address and 16-bit data. Read data is registered. There are two ways to acknowledge an event:
- write a mask with zeros in the flag positions to be cleared, into the status word;
- write any value to a per-timer acknowledge word.

A mode word decides how count reads are captured. In the default mode, every read of either word of the timer-0/1 pair re-captures both counters. In the coherent mode, only a read of the low word captures the pair. The high word then returns the timer-1 value as it was at that moment.

Top module: `timer_bank`

Word map:

| Address | Register |
|---|---|
| 0 | Control: timer i uses bits 4i+3..4i, laid out as {irq_en, run, rate[1:0]} |
| 1 | Mode |
| 2 | Status: flag i in bit i |
| 3 to 5 | Reload, timers 0 to 2 |
| 6 | Pair low word (timer 0 count) |
| 7 | Pair high word (timer 1 count) |
| 8 | Timer 2 count |
| 9 to 11 | Acknowledge, timers 0 to 2 |

## Requirements
- R1: After reset the control, mode and status words, every count, the interrupt line and the read data are all zero.
- R2: The rate field selects the tick period in system clocks as BASE_DIV times 1, 2, 4 or 8 for the codes 00, 01, 10, 11. A counter with reload R therefore raises events exactly (R+1)*BASE_DIV*2^code clocks apart.
- R3: A counter whose run bit (control bit 4i+2) is 0 holds its count unchanged.
- R4: Writing a reload word stores the value and loads the count at once, and reading the reload word (3+i) returns the stored value. When a running counter takes a tick at zero, it reloads from that stored value.
- R5: With the interrupt-enable bit (control bit 4i+3) at 0, a counter that wraps never sets its flag.
- R6: The interrupt output is 1 exactly when at least one of the three status flags (status bits 2..0) is 1. Several flags may be set together.
- R7: A write to the status word clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R8: A write of any value to acknowledge word 9+i clears flag i only.
- R9: The mode word (address 1) stores and returns all 16 bits. Only bit 0 changes behaviour.
- R10: With mode bit 0 at 0, every read of word 6 or 7 captures both timer-0 and timer-1 counts, and returns the current count. Word 8 returns the current timer-2 count.
- R11: With mode bit 0 at 1, a read of word 6 captures timer 1. Word 7 returns that captured value until the next capture, even if the live count changes.
- R12: Read data appears on the clock edge after the read strobe. Reads of the acknowledge words and of unused addresses 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Combined interrupt, OR of the flags |

## Verification
The hardest things to reach from the ports are the prescaler phase and the pair capture while the counts differ. The phase at which a counter is enabled is arbitrary. The stimulus therefore times the interval between two successive interrupt rises, acknowledging between them, so each rate code is measured exactly whatever the phase. For the coherent-pair case, the counters are stopped and a reload write changes timer 1's live count between a low-word read and a high-word read. This separates the held value from the live one without depending on when ticks land.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int NTMR = 3;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_MODE = 4'd1;
  localparam logic [3:0] A_STAT = 4'd2;
  localparam logic [3:0] A_RLD0 = 4'd3;
  localparam logic [3:0] A_PLO  = 4'd6;
  localparam logic [3:0] A_PHI  = 4'd7;
  localparam logic [3:0] A_SOLO = 4'd8;
  localparam logic [3:0] A_ACK0 = 4'd9;

  // per-timer control nibble: {irq_en, run, rate[1:0]}
  typedef struct packed {
    logic       irq_en;
    logic       run;
    logic [1:0] rate;
  } tmr_ctl_t;
endpackage

// File: rtl/tbank_tick.sv
module tbank_tick #(
  parameter int BASE_DIV = 50,
  parameter int NRATE    = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NRATE-1:0] rate_tick
);
  localparam int PW  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int DVW = (NRATE > 1) ? NRATE - 1 : 1;

  logic [PW-1:0]  pre_q;
  logic [DVW-1:0] div_q;
  logic           base;

  assign base = (pre_q == PW'(BASE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= base ? '0 : pre_q + 1'b1;
      if (base) div_q <= div_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NRATE; k++) begin : g_rate
    if (k == 0) begin : g_base
      assign rate_tick[k] = base;
    end else begin : g_div
      assign rate_tick[k] = base && (&div_q[k-1:0]);
    end
  end
endmodule

// File: rtl/tbank_timer.sv
module tbank_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          irq_en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] reload,
  output logic          flag,
  output logic          flag_nxt
);
  logic hit;

  assign hit      = run && tick && (cnt == '0) && !load;
  // a new event wins over a clear in the same cycle
  assign flag_nxt = (hit && irq_en) ? 1'b1 : (clr ? 1'b0 : flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
      flag   <= 1'b0;
    end else begin
      flag <= flag_nxt;
      if (load) begin
        cnt    <= load_val;
        reload <= load_val;
      end else if (run && tick) begin
        cnt <= (cnt == '0) ? reload : cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tbank_pkg::*;
#(
  parameter int DW       = 16,
  parameter int BASE_DIV = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NRATE = 4;
  localparam int CTLW  = NTMR * $bits(tmr_ctl_t);

  logic [CTLW-1:0]           ctrl_q;
  tmr_ctl_t [NTMR-1:0]       ctl;
  logic [DW-1:0]             mode_q;
  logic [DW-1:0]             pair_hold_q;
  logic [NRATE-1:0]          rate_tick;
  logic [NTMR-1:0]           flag_q, flag_nxt, ld, clr, tick, run, ie;
  logic [NTMR-1:0][DW-1:0]   cnt_w, rld_w;
  logic [DW-1:0]             rd_mux;
  logic                      pair_cap;

  assign ctl = ctrl_q;

  tbank_tick #(.BASE_DIV(BASE_DIV), .NRATE(NRATE)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .rate_tick (rate_tick)
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    assign run[i]  = ctl[i].run;
    assign ie[i]   = ctl[i].irq_en;
    assign tick[i] = rate_tick[ctl[i].rate];
    assign ld[i]   = bus_wr && (bus_addr == A_RLD0 + 4'(i));
    assign clr[i]  = bus_wr && (((bus_addr == A_STAT) && !bus_wdata[i]) ||
                                (bus_addr == A_ACK0 + 4'(i)));

    tbank_timer #(.CW(DW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick[i]),
      .run      (run[i]),
      .irq_en   (ie[i]),
      .load     (ld[i]),
      .load_val (bus_wdata),
      .clr      (clr[i]),
      .cnt      (cnt_w[i]),
      .reload   (rld_w[i]),
      .flag     (flag_q[i]),
      .flag_nxt (flag_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTLW-1:0];
      if (bus_addr == A_MODE) mode_q <= bus_wdata;
    end
  end

  // pair capture: every pair read in mode 0, low-word reads only in mode 1
  assign pair_cap = bus_rd && ((bus_addr == A_PLO) ||
                               ((bus_addr == A_PHI) && !mode_q[0]));

  always_ff @(posedge clk) begin
    if (rst)           pair_hold_q <= '0;
    else if (pair_cap) pair_hold_q <= cnt_w[1];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:                   rd_mux = DW'(ctrl_q);
      A_MODE:                   rd_mux = mode_q;
      A_STAT:                   rd_mux = DW'(flag_q);
      A_RLD0, A_RLD0 + 4'd1,
      A_RLD0 + 4'd2:            rd_mux = rld_w[bus_addr - A_RLD0];
      A_PLO:                    rd_mux = cnt_w[0];
      A_PHI:                    rd_mux = mode_q[0] ? pair_hold_q : cnt_w[1];
      A_SOLO:                   rd_mux = cnt_w[2];
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |flag_nxt;
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import tbank_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [3:0]              bus_addr,
  input logic [DW-1:0]           bus_rdata,
  input logic                    irq,
  input logic [NTMR-1:0]         flag_q,
  input logic [NTMR-1:0]         run,
  input logic [NTMR-1:0]         ie,
  input logic [NTMR-1:0][DW-1:0] cnt_w
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && flag_q == '0));

  assert_irq_is_or_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (|flag_q));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr > 4'd11) |-> bus_rdata == '0);

  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(run[i]) && !$past(bus_wr && bus_addr == A_RLD0 + 4'(i)))
        |-> $stable(cnt_w[i]));

    assert_flag_needs_ie_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[i]) |-> $past(ie[i]));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
      $past(bus_wr && bus_addr == A_ACK0 + 4'(i) && !run[i]) |-> !flag_q[i]);
  end
endmodule

bind timer_bank timer_bank_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .flag_q    (flag_q),
  .run       (run),
  .ie        (ie),
  .cnt_w     (cnt_w)
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
  localparam int DW = 16;
  localparam int BD = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic rd_seen = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  timer_bank #(.DW(DW), .BASE_DIV(BD)) i_timer_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= bus_rd;
  end

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [DW-1:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int c);
    while (!irq) @(negedge clk);
    c = cyc;
  endtask

  task automatic measure(int t, int s, string tag);
    int c1, c2;
    wr(4'(3 + t), 16'd3);
    wr(4'd0, 16'((4'b1100 | 4'(s)) << (4 * t)));
    wait_irq(c1);
    wr(4'(9 + t), 16'h0);
    wait_irq(c2);
    check(c2 - c1, 4 * BD * (1 << s), tag);
    wr(4'd0, 16'h0);
    wr(4'(9 + t), 16'hFFFF);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check(int'(irq), 0, "R1 irq after reset");
    rd(4'd0, 16'h0, "R1 control");
    rd(4'd1, 16'h0, "R1 mode");
    rd(4'd2, 16'h0, "R1 status");
    rd(4'd6, 16'h0, "R1 count0");
    rd(4'd8, 16'h0, "R1 count2");
    // R9 mode word readback
    wr(4'd1, 16'hA5A4);
    rd(4'd1, 16'hA5A4, "R9 mode readback");
    wr(4'd1, 16'h0);
    // R12 zero reads
    rd(4'd13, 16'h0, "R12 unused address");
    rd(4'd9, 16'h0, "R12 ack word read");
    // R4 reload load, R3 hold while stopped
    wr(4'd3, 16'd10);
    rd(4'd3, 16'd10, "R4 reload readback");
    rd(4'd6, 16'd10, "R4 count loaded");
    idle(50);
    rd(4'd6, 16'd10, "R3 stopped count holds");
    // R2 rate codes, periods measured between events
    measure(0, 0, "R2 timer0 rate 00");
    measure(0, 1, "R2 timer0 rate 01");
    measure(0, 2, "R2 timer0 rate 10");
    measure(0, 3, "R2 timer0 rate 11");
    measure(2, 3, "R2 timer2 rate 11");
    measure(1, 1, "R4 timer1 periodic reload");
    // R5 run without interrupt enable
    wr(4'd3, 16'd3);
    wr(4'd0, 16'h0004);
    idle(100);
    rd(4'd2, 16'h0, "R5 no flag without enable");
    check(int'(irq), 0, "R5 irq stays low");
    wr(4'd0, 16'h0);
    // R6 R7 R8 multiple flags and both clear paths
    wr(4'd3, 16'd1); wr(4'd4, 16'd1); wr(4'd5, 16'd1);
    wr(4'd0, 16'h0CCC);
    idle(40);
    wr(4'd0, 16'h0);
    rd(4'd2, 16'h7, "R6 all flags set");
    check(int'(irq), 1, "R6 irq with flags");
    wr(4'd2, 16'hFFFD);
    rd(4'd2, 16'h5, "R7 write zero clears one flag");
    check(int'(irq), 1, "R6 irq with remaining flags");
    wr(4'd11, 16'h1234);
    rd(4'd2, 16'h1, "R8 ack clears only its flag");
    wr(4'd2, 16'h0);
    rd(4'd2, 16'h0, "R7 clear remaining");
    check(int'(irq), 0, "R6 irq low when no flags");
    // R10 R11 count capture modes
    wr(4'd3, 16'd100); wr(4'd4, 16'd200); wr(4'd5, 16'd300);
    rd(4'd7, 16'd200, "R10 high word live in mode 0");
    wr(4'd1, 16'h0001);
    rd(4'd6, 16'd100, "R11 low word read");
    wr(4'd4, 16'd222);
    rd(4'd7, 16'd200, "R11 high word holds captured value");
    rd(4'd8, 16'd300, "R10 timer2 count");
    wr(4'd1, 16'h0000);
    rd(4'd7, 16'd222, "R10 every read captures");
    wr(4'd1, 16'h0001);
    rd(4'd7, 16'd222, "R10 capture from high-word read");
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule